// File: doc/BRIEF.md
# Streaming Row-Wise SAD Engine

This block scores how well each small square tile of a sensor image (a sub-aperture of S×S pixels) matches a shared reference image at every one of A×A candidate offsets. The score at offset (k,l) is the sum, over all tile pixels (i,j), of |P(i,j) − R(i+k, j+l)|. The reference image is S+A−1 pixels on a side.

Pixels arrive one per clock in raster order along the full sensor row, so the S pixels of one tile row are followed by the S pixels of the next tile on that image row. The engine holds no window of pixels. Each arriving pixel updates all A×A running scores in the same cycle. At the end of a tile row the running scores are parked in a small per-tile store and fetched back when that tile's next row starts. A separate unit supplies, with each pixel, the A×A reference values that pixel is compared against. After a tile's last row, the finished score array is presented with a one-cycle strobe and the tile index.

Top module: `sad_stream_engine`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0 and `out_scores` is all zero.
- R2: For every tile, score (k,l) equals the sum over i,j in 0..S-1 of |P(i,j) − R(i+k,j+l)|. It sits at bits [(k·A+l)·ACC_W +: ACC_W] of `out_scores`. Reference value R(i+k,j+l) is driven at bits [(k·A+l)·PIX_W +: PIX_W] of `ref_win` with pixel (i,j).
- R3: The absolute difference is correct for both signs of reference minus pixel, including the extremes 0 and 2^PIX_W−1.
- R4: Up to NSUB tiles interleave along an image row. Each tile's scores continue correctly across its rows, with no mixing between tiles.
- R5: A pixel at row 0, column 0 starts its tile from zero, so stored scores from an earlier frame never leak into a new one.
- R6: `out_valid` is high for exactly the one cycle after the pixel at row S−1, column S−1 is accepted, and `out_sub` then carries that pixel's tile index.
- R7: Cycles with `in_valid` low change no score, whatever the other inputs carry.
- R8: Scores never overflow. ACC_W = PIX_W + ceil(log2(S·S)), so the worst case S·S·(2^PIX_W−1) is represented exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Pixel present this cycle |
| in_pix | input | PIX_W | Tile pixel value |
| in_sub | input | SUB_W | Tile index along the image row |
| in_row | input | POS_W | Row of the pixel inside its tile |
| in_col | input | POS_W | Column of the pixel inside its tile |
| ref_win | input | A·A·PIX_W | Reference values for all offsets of this pixel |
| out_valid | output | 1 | Finished score array strobe |
| out_sub | output | SUB_W | Tile index of the finished array |
| out_scores | output | A·A·ACC_W | Finished scores, offset (k,l) at slot k·A+l |

## Verification
The bench builds the engine with S=8, A=3, three tiles per row and 8-bit pixels. With these values, a tile row ends while other tiles still hold parked partial scores, and back-to-back frames reuse the same store slots. Random idle gaps fall at tile-row boundaries as well as mid-row. Full-scale pixel and reference values reach the 14-bit score ceiling exactly, and a tile copied from a shifted part of the reference gives a zero score at one known offset.

// File: rtl/sad_pkg.sv
// Shared types for the streaming SAD engine.
package sad_pkg;
    // Where an accumulator takes its starting value for the current pixel.
    typedef enum logic [1:0] {
        BASE_ZERO = 2'd0,   // first pixel of a tile's first row
        BASE_MEM  = 2'd1,   // first pixel of a later row: parked partial score
        BASE_ACC  = 2'd2    // any other pixel: running accumulator
    } base_sel_e;
endpackage

// File: rtl/sad_pe.sv
// Absolute-difference element: subtracts the pixel from the reference and,
// when the difference is negative, takes its two's complement.
// Assumes unsigned inputs of PIX_W bits. Purely combinational.
module sad_pe #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] ref_val,
    input  logic [PIX_W-1:0] pix_val,
    output logic [PIX_W-1:0] ad
);
    logic [PIX_W:0]   diff;
    logic [PIX_W-1:0] negated;

    // Signed difference, invert-plus-one, then pick the non-negative value.
    always_comb begin
        diff    = {1'b0, ref_val} - {1'b0, pix_val};
        negated = ~diff[PIX_W-1:0] + PIX_W'(1);
        ad      = diff[PIX_W] ? negated : diff[PIX_W-1:0];
    end
endmodule

// File: rtl/sad_row_store.sv
// Partial-score store: one word of all A*A scores per tile along an image row.
// Write is synchronous; read is combinational so a restored row can start
// in the same cycle as its first pixel. Contents need no reset: a tile's
// first row never reads them.
module sad_row_store #(
    parameter int DEPTH  = 4,
    parameter int WIDTH  = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WIDTH-1:0]  rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Park a tile's scores at the end of its row.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Fetch the parked scores for the tile now arriving.
    assign rdata = mem[raddr];
endmodule

// File: rtl/sad_stream_engine.sv
// Streaming SAD engine. Each valid pixel updates all A*A offset scores in one
// cycle. Scores move to a per-tile store at the end of each tile row and are
// emitted, registered, after the tile's last pixel.
// Assumes pixels of one tile row arrive as columns 0..S-1 in order, and that
// S is a power of two so row/column fit POS_W exactly.
module sad_stream_engine #(
    parameter int PIX_W = 8,
    parameter int S     = 8,
    parameter int A     = 3,
    parameter int NSUB  = 4,
    localparam int NA     = A * A,
    localparam int ACC_W  = PIX_W + $clog2(S * S),
    localparam int SUB_W  = (NSUB > 1) ? $clog2(NSUB) : 1,
    localparam int POS_W  = (S > 1) ? $clog2(S) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [PIX_W-1:0]      in_pix,
    input  logic [SUB_W-1:0]      in_sub,
    input  logic [POS_W-1:0]      in_row,
    input  logic [POS_W-1:0]      in_col,
    input  logic [NA*PIX_W-1:0]   ref_win,
    output logic                  out_valid,
    output logic [SUB_W-1:0]      out_sub,
    output logic [NA*ACC_W-1:0]   out_scores
);
    import sad_pkg::*;

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(S - 1);
    localparam int               MAX_SCORE = S * S * ((1 << PIX_W) - 1);

    logic [NA*ACC_W-1:0] acc_q;
    logic [NA*ACC_W-1:0] acc_nxt;
    logic [NA*ACC_W-1:0] parked;
    base_sel_e           base_sel;
    logic                row_end;
    logic                tile_done;

    // Choose where this pixel's accumulation starts.
    always_comb begin
        if (in_col != '0)      base_sel = BASE_ACC;
        else if (in_row == '0) base_sel = BASE_ZERO;
        else                   base_sel = BASE_MEM;
    end

    assign row_end   = in_valid && (in_col == LAST_POS);
    assign tile_done = row_end && (in_row == LAST_POS);

    // One element and one adder per candidate offset.
    for (genvar g = 0; g < NA; g++) begin : g_off
        logic [PIX_W-1:0] ad;
        logic [ACC_W-1:0] base;

        sad_pe #(.PIX_W(PIX_W)) u_pe (
            .ref_val (ref_win[g*PIX_W +: PIX_W]),
            .pix_val (in_pix),
            .ad      (ad)
        );

        // Starting value for this offset's score.
        always_comb begin
            case (base_sel)
                BASE_ZERO: base = '0;
                BASE_MEM:  base = parked[g*ACC_W +: ACC_W];
                default:   base = acc_q[g*ACC_W +: ACC_W];
            endcase
        end

        assign acc_nxt[g*ACC_W +: ACC_W] = base + ACC_W'(ad);

        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_scores[g*ACC_W +: ACC_W] <= ACC_W'(MAX_SCORE))); // R8
    end

    sad_row_store #(
        .DEPTH  (NSUB),
        .WIDTH  (NA * ACC_W),
        .ADDR_W (SUB_W)
    ) u_store (
        .clk   (clk),
        .we    (row_end),
        .waddr (in_sub),
        .wdata (acc_nxt),
        .raddr (in_sub),
        .rdata (parked)
    );

    // Running scores advance only on accepted pixels.
    always_ff @(posedge clk) begin
        if (!rst_n)        acc_q <= '0;
        else if (in_valid) acc_q <= acc_nxt;
    end

    // Register the finished array and strobe after a tile's last pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sub    <= '0;
            out_scores <= '0;
        end else begin
            out_valid <= tile_done;
            if (tile_done) begin
                out_sub    <= in_sub;
                out_scores <= acc_nxt;
            end
        end
    end

    AST_DONE_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_row == LAST_POS && in_col == LAST_POS)); // R6
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(acc_q)); // R7
    AST_SUB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sub <= SUB_W'(NSUB - 1))); // R4
endmodule

// File: tb/tb_sad_stream_engine.sv
module tb_sad_stream_engine;
    localparam int PIX_W = 8;
    localparam int S     = 8;
    localparam int A     = 3;
    localparam int NSUB  = 3;
    localparam int NA    = A * A;
    localparam int ACC_W = PIX_W + $clog2(S * S);
    localparam int SUB_W = $clog2(NSUB);
    localparam int POS_W = $clog2(S);
    localparam int RS    = S + A - 1;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic [PIX_W-1:0]    in_pix = '0;
    logic [SUB_W-1:0]    in_sub = '0;
    logic [POS_W-1:0]    in_row = '0;
    logic [POS_W-1:0]    in_col = '0;
    logic [NA*PIX_W-1:0] ref_win = '0;
    logic                out_valid;
    logic [SUB_W-1:0]    out_sub;
    logic [NA*ACC_W-1:0] out_scores;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int pix    [NSUB][S][S];
    int refimg [RS][RS];
    int expv   [NSUB][NA];

    always #10 clk = ~clk;   // 50 MHz

    sad_stream_engine #(.PIX_W(PIX_W), .S(S), .A(A), .NSUB(NSUB)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
        .in_sub(in_sub), .in_row(in_row), .in_col(in_col), .ref_win(ref_win),
        .out_valid(out_valid), .out_sub(out_sub), .out_scores(out_scores)
    );

    function automatic int absd(int a, int b);
        return (a > b) ? a - b : b - a;
    endfunction

    // Fill reference and tiles. mode 0 random, 1 pixel max / ref 0,
    // 2 pixel 0 / ref max, 3 tiles copied from reference at offset (1,2).
    task automatic fill(int mode);
        for (int r = 0; r < RS; r++)
            for (int c = 0; c < RS; c++)
                refimg[r][c] = (mode == 1) ? 0 : (mode == 2) ? 255 : int'($urandom % 256);
        for (int s = 0; s < NSUB; s++)
            for (int i = 0; i < S; i++)
                for (int j = 0; j < S; j++)
                    pix[s][i][j] = (mode == 1) ? 255 : (mode == 2) ? 0 :
                                   (mode == 3) ? refimg[i+1][j+2] : int'($urandom % 256);
        for (int s = 0; s < NSUB; s++)
            for (int k = 0; k < A; k++)
                for (int l = 0; l < A; l++) begin
                    int sum = 0;
                    for (int i = 0; i < S; i++)
                        for (int j = 0; j < S; j++)
                            sum += absd(pix[s][i][j], refimg[i+k][j+l]);
                    expv[s][k*A+l] = sum;
                end
    endtask

    task automatic check_tile(int s, string tag);
        checks++;
        if (out_valid !== 1'b1 || out_sub !== SUB_W'(s)) begin
            fails++;
            $display("FAIL R6: out_valid=%0b out_sub=%0d, expected 1 and %0d",
                     out_valid, out_sub, s);
        end
        for (int g = 0; g < NA; g++) begin
            checks++;
            if (out_scores[g*ACC_W +: ACC_W] !== ACC_W'(expv[s][g])) begin
                fails++;
                $display("FAIL %s: tile %0d offset %0d score=%0d expected %0d",
                         tag, s, g, out_scores[g*ACC_W +: ACC_W], expv[s][g]);
            end
        end
    endtask

    // Stream one frame in raster order with an idle-cycle percentage.
    task automatic send_frame(int gap, string tag);
        for (int i = 0; i < S; i++)
            for (int s = 0; s < NSUB; s++)
                for (int j = 0; j < S; j++) begin
                    while (int'($urandom % 100) < gap) begin
                        @(negedge clk);
                        in_valid = 1'b0;                 // R7: garbage on idle cycles
                        in_pix   = PIX_W'($urandom);
                        in_col   = '0;
                        in_row   = '0;
                        ref_win  = {NA{PIX_W'($urandom)}};
                    end
                    @(negedge clk);
                    in_valid = 1'b1;
                    in_pix   = PIX_W'(pix[s][i][j]);
                    in_sub   = SUB_W'(s);
                    in_row   = POS_W'(i);
                    in_col   = POS_W'(j);
                    for (int k = 0; k < A; k++)
                        for (int l = 0; l < A; l++)
                            ref_win[(k*A+l)*PIX_W +: PIX_W] = PIX_W'(refimg[i+k][j+l]);
                    if (i == S - 1 && j == S - 1) begin
                        @(posedge clk);
                        #1;
                        check_tile(s, tag);
                    end
                end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        checks++;   // R1
        if (out_valid !== 1'b0 || out_scores !== '0) begin
            fails++;
            $display("FAIL R1: out_valid=%0b scores=%0h, expected 0 and 0",
                     out_valid, out_scores);
        end
        fill(0); send_frame(0,  "R2");     // R2, R4 random, dense
        fill(1); send_frame(0,  "R8");     // R8 full-scale, R3 ref below pixel
        fill(2); send_frame(10, "R3");     // R3 ref above pixel, R5 fresh frame
        fill(3); send_frame(0,  "R5");     // R5 zero score at offset (1,2)
        checks++;
        if (out_scores[(1*A+2)*ACC_W +: ACC_W] !== '0) begin
            fails++;
            $display("FAIL R2: matched offset score=%0d expected 0",
                     out_scores[(1*A+2)*ACC_W +: ACC_W]);
        end
        for (int f = 0; f < 3; f++) begin
            fill(0); send_frame(30, "R7");  // R7, R4 with idle gaps
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule